// File: doc/BRIEF.md
# Mixed-Page-Size Skewed-Associative Second-Level TLB

This block is a second-level translation cache. One storage array holds three kinds of entry: 4KB translations, ordinary 2MB translations, and speculative 2MB entries. The speculative entries cover a guest large page that the hypervisor backed with aligned 4KB system pages. The array is skew-associative. Each way computes its slot from the page number with its own XOR hash, so the two page sizes share the ways without a fixed set split.

Every lookup probes the array for a 4KB match and for a 2MB match at the same time. After a fixed pipeline delay it reports the kind of hit and the physical page number. For a 2MB hit, the physical page is the stored frame number joined with the low nine page-number bits of the request. A 4KB hit is exact and takes precedence, so the caller can use it to confirm or refute a speculation made at the first level.

Fills come from the page walker. Each fill states the page size and the speculation flag. On a 2MB entry, a tag bit that 2MB entries do not otherwise need carries that flag. The victim way is chosen in this order: a slot that already holds the same translation, then a free slot, then a round-robin pointer.

Top module: `l2tlb_skew`

## Requirements
- R1: After reset every slot is empty. Every lookup reports kind 0 (miss) with a physical page number of 0.
- R2: A lookup is sampled on the rising edge where lkp_valid_i is high. Its result is on the outputs for exactly one cycle, after the LAT-th rising edge, where the sampling edge counts as the first (LAT defaults to 7). Before that edge lkp_valid_o stays low.
- R3: A lookup whose page number equals the page number of a stored 4KB entry reports kind 1. It returns the stored physical page number unchanged.
- R4: A lookup that falls in a stored non-speculative 2MB frame reports kind 2. "Falls in" means that page-number bits 35:9 are equal. The returned page is the stored physical page bits 35:9 joined with request bits 8:0. The low nine bits of the physical page given at fill time are discarded.
- R5: A 2MB fill with fill_spec_i high produces kind 3 hits, with the same page formation as R4. On a 4KB fill, fill_spec_i has no effect and hits still report kind 1.
- R6: When a lookup matches both a 4KB entry and a 2MB entry, the 4KB result (kind 1 and its page) is reported.
- R7: Way 0 indexes with key bits 6:0. Way w>0 indexes with key[6:0] XOR (key[13:7] rotated left by w). The key is the page number for 4KB, and page-number bits 35:9 for 2MB.
- R8: A fill overwrites, in place, a slot in its candidate set that holds the same size and frame. Failing that, it takes the lowest-numbered empty way. Failing that, it takes the way named by a round-robin pointer. The pointer starts at 0 and advances by one (mod 4) only when it is used.
- R9: A fill sampled on the same edge as a lookup is not visible to that lookup. It is visible to lookups sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | 36 | Lookup virtual page number |
| fill_valid_i | input | 1 | Fill request |
| fill_vpn_i | input | 36 | Fill virtual page number |
| fill_ppn_i | input | 36 | Fill physical page number |
| fill_big_i | input | 1 | Fill is a 2MB entry |
| fill_spec_i | input | 1 | 2MB fill is speculative |
| lkp_valid_o | output | 1 | Lookup result valid |
| lkp_kind_o | output | 2 | 0 miss, 1 4KB, 2 2MB, 3 speculative 2MB |
| lkp_ppn_o | output | 36 | Resulting physical page number |

## Verification
The assertions check three properties on every cycle. No two ways ever hold the same translation, which shows up as a single matching way per page size. A fill with a free slot available never evicts a valid entry. The round-robin pointer only ever steps by one. Hit kind, page formation, 4KB priority, the latency and same-cycle fill visibility can only be shown by the bench scenarios. These include a collision set that forces eviction in all four ways and a long sweep of mixed-size fills with clustered page numbers, checked against a reference model of the hash and victim rules.

// File: rtl/l2tlb_pkg.sv
`timescale 1ns/1ps
package l2tlb_pkg;
  typedef enum logic [1:0] {
    KIND_MISS = 2'd0,
    KIND_4K   = 2'd1,
    KIND_2M   = 2'd2,
    KIND_SPEC = 2'd3
  } kind_e;
endpackage

// File: rtl/l2tlb_hash.sv
`timescale 1ns/1ps
module l2tlb_hash #(
  parameter int KEY_W = 36,
  parameter int IW    = 7,
  parameter int WAYS  = 4
) (
  input  logic [KEY_W-1:0]         key_i,
  output logic [WAYS-1:0][IW-1:0]  idx_o
);
  logic [IW-1:0]   lo;
  logic [IW-1:0]   hi;
  logic [2*IW-1:0] dbl;

  assign lo  = key_i[IW-1:0];
  assign hi  = key_i[2*IW-1:IW];
  assign dbl = {hi, hi};

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    if (w == 0) begin : g_plain
      assign idx_o[w] = lo;
    end else begin : g_skew
      // rotate hi left by w
      assign idx_o[w] = lo ^ dbl[2*IW-1-(w % IW) -: IW];
    end
  end
endmodule

// File: rtl/l2tlb_store.sv
`timescale 1ns/1ps
module l2tlb_store #(
  parameter int VPN_W = 36,
  parameter int PPN_W = 36,
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int IW    = 7,
  parameter int OFF_W = 9
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [VPN_W-1:0]            lkp_vpn_i,
  input  logic [WAYS-1:0][IW-1:0]     idx4_i,
  input  logic [WAYS-1:0][IW-1:0]     idx2_i,
  input  logic [WAYS-1:0][IW-1:0]     fidx_i,
  input  logic [VPN_W-1:0]            fill_vpn_i,
  input  logic                        fill_big_i,
  input  logic                        wr_i,
  input  logic [WAYS-1:0]             wr_oh_i,
  input  logic [VPN_W-1:0]            wr_tag_i,
  input  logic [PPN_W-1:0]            wr_ppn_i,
  output logic [WAYS-1:0]             hit4_o,
  output logic [WAYS-1:0]             hit2_o,
  output logic [WAYS-1:0]             spec2_o,
  output logic [WAYS-1:0]             fvalid_o,
  output logic [WAYS-1:0]             fmatch_o,
  output logic [WAYS-1:0][PPN_W-1:0]  ppn4_o,
  output logic [WAYS-1:0][PPN_W-1:0]  ppn2_o
);
  logic             valid_q [WAYS][SETS];
  logic             big_q   [WAYS][SETS];
  logic [VPN_W-1:0] tag_q   [WAYS][SETS];
  logic [PPN_W-1:0] ppn_q   [WAYS][SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++)
          valid_q[w][s] <= 1'b0;
    end else if (wr_i) begin
      for (int w = 0; w < WAYS; w++)
        if (wr_oh_i[w]) valid_q[w][fidx_i[w]] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) begin
      for (int w = 0; w < WAYS; w++)
        if (wr_oh_i[w]) begin
          big_q[w][fidx_i[w]] <= fill_big_i;
          tag_q[w][fidx_i[w]] <= wr_tag_i;
          ppn_q[w][fidx_i[w]] <= wr_ppn_i;
        end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_probe
    logic             v4, b4, v2, b2, vf, bf;
    logic [VPN_W-1:0] t4, t2, tf;
    assign v4 = valid_q[w][idx4_i[w]];
    assign b4 = big_q[w][idx4_i[w]];
    assign t4 = tag_q[w][idx4_i[w]];
    assign v2 = valid_q[w][idx2_i[w]];
    assign b2 = big_q[w][idx2_i[w]];
    assign t2 = tag_q[w][idx2_i[w]];
    assign vf = valid_q[w][fidx_i[w]];
    assign bf = big_q[w][fidx_i[w]];
    assign tf = tag_q[w][fidx_i[w]];

    assign hit4_o[w]  = v4 && !b4 && (t4 == lkp_vpn_i);
    assign hit2_o[w]  = v2 && b2 && (t2[VPN_W-1:OFF_W] == lkp_vpn_i[VPN_W-1:OFF_W]);
    assign spec2_o[w] = t2[0];  // spare tag bit of a 2MB entry
    assign ppn4_o[w]  = ppn_q[w][idx4_i[w]];
    assign ppn2_o[w]  = ppn_q[w][idx2_i[w]];

    assign fvalid_o[w] = vf;
    assign fmatch_o[w] = vf && (bf == fill_big_i) &&
                         (fill_big_i ? (tf[VPN_W-1:OFF_W] == fill_vpn_i[VPN_W-1:OFF_W])
                                     : (tf == fill_vpn_i));
  end
endmodule

// File: rtl/l2tlb_victim.sv
`timescale 1ns/1ps
module l2tlb_victim #(
  parameter int WAYS = 4,
  localparam int WW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fill_i,
  input  logic [WAYS-1:0] fvalid_i,
  input  logic [WAYS-1:0] fmatch_i,
  output logic [WAYS-1:0] way_oh_o
);
  logic [WW-1:0] rr_q;
  logic [WW-1:0] way;
  logic          use_rr;

  always_comb begin
    way    = rr_q;
    use_rr = 1'b1;
    if (|fmatch_i) begin
      use_rr = 1'b0;
      for (int w = WAYS-1; w >= 0; w--) if (fmatch_i[w]) way = WW'(w);
    end else if (!(&fvalid_i)) begin
      use_rr = 1'b0;
      for (int w = WAYS-1; w >= 0; w--) if (!fvalid_i[w]) way = WW'(w);
    end
  end

  always_comb begin
    way_oh_o = '0;
    way_oh_o[way] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rr_q <= '0;
    else if (fill_i && use_rr)  rr_q <= (rr_q == WW'(WAYS-1)) ? '0 : rr_q + 1'b1;
  end

  AST_FREE_BEFORE_EVICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !(|fmatch_i) && !(&fvalid_i)) |-> !(|(way_oh_o & fvalid_i))) // R8
    else $error("victim evicted a valid way while a free way existed");

  AST_RR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rr_q != $past(rr_q)) |->
      (rr_q == (($past(rr_q) == WW'(WAYS-1)) ? '0 : $past(rr_q) + 1'b1))) // R8
    else $error("round-robin pointer jumped");
endmodule

// File: rtl/l2tlb_pipe.sv
`timescale 1ns/1ps
module l2tlb_pipe #(
  parameter int W   = 38,
  parameter int LAT = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [LAT-1:0] vld_q;
  logic [W-1:0]   dat_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < LAT; i++) dat_q[i] <= '0;
    end else begin
      vld_q[0] <= valid_i;
      dat_q[0] <= valid_i ? data_i : '0;
      for (int i = 1; i < LAT; i++) begin
        vld_q[i] <= vld_q[i-1];
        dat_q[i] <= dat_q[i-1];
      end
    end
  end

  assign valid_o = vld_q[LAT-1];
  assign data_o  = dat_q[LAT-1];
endmodule

// File: rtl/l2tlb_skew.sv
`timescale 1ns/1ps
module l2tlb_skew
  import l2tlb_pkg::*;
#(
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 36,
  parameter int ENTRIES = 512,
  parameter int WAYS    = 4,
  parameter int OFF_W   = 9,
  parameter int LAT     = 7,
  localparam int SETS   = ENTRIES / WAYS,
  localparam int IW     = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_big_i,
  input  logic             fill_spec_i,
  output logic             lkp_valid_o,
  output logic [1:0]       lkp_kind_o,
  output logic [PPN_W-1:0] lkp_ppn_o
);
  initial begin
    if (2*IW > VPN_W - OFF_W) $error("hash needs 2*IW key bits of a 2MB frame");
  end

  logic [VPN_W-1:0]           key2, keyf, wr_tag;
  logic [WAYS-1:0][IW-1:0]    idx4, idx2, fidx;
  logic [WAYS-1:0]            hit4, hit2, spec2, fvalid, fmatch, wr_oh;
  logic [WAYS-1:0][PPN_W-1:0] ppn4, ppn2;
  kind_e                      kind_d;
  logic [PPN_W-1:0]           ppn_d;

  assign key2 = {{OFF_W{1'b0}}, lkp_vpn_i[VPN_W-1:OFF_W]};
  assign keyf = fill_big_i ? {{OFF_W{1'b0}}, fill_vpn_i[VPN_W-1:OFF_W]} : fill_vpn_i;
  // 2MB tag: frame bits, spare low bits zero except bit 0 = spec
  assign wr_tag = fill_big_i ?
                  {fill_vpn_i[VPN_W-1:OFF_W], {(OFF_W-1){1'b0}}, fill_spec_i} : fill_vpn_i;

  l2tlb_hash #(.KEY_W(VPN_W), .IW(IW), .WAYS(WAYS)) u_hash4 (.key_i(lkp_vpn_i), .idx_o(idx4));
  l2tlb_hash #(.KEY_W(VPN_W), .IW(IW), .WAYS(WAYS)) u_hash2 (.key_i(key2),      .idx_o(idx2));
  l2tlb_hash #(.KEY_W(VPN_W), .IW(IW), .WAYS(WAYS)) u_hashf (.key_i(keyf),      .idx_o(fidx));

  l2tlb_store #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .WAYS(WAYS), .SETS(SETS), .IW(IW), .OFF_W(OFF_W)
  ) u_store (
    .clk_i, .rst_ni,
    .lkp_vpn_i, .idx4_i(idx4), .idx2_i(idx2), .fidx_i(fidx),
    .fill_vpn_i, .fill_big_i,
    .wr_i(fill_valid_i), .wr_oh_i(wr_oh), .wr_tag_i(wr_tag), .wr_ppn_i(fill_ppn_i),
    .hit4_o(hit4), .hit2_o(hit2), .spec2_o(spec2),
    .fvalid_o(fvalid), .fmatch_o(fmatch),
    .ppn4_o(ppn4), .ppn2_o(ppn2)
  );

  l2tlb_victim #(.WAYS(WAYS)) u_victim (
    .clk_i, .rst_ni, .fill_i(fill_valid_i),
    .fvalid_i(fvalid), .fmatch_i(fmatch), .way_oh_o(wr_oh)
  );

  always_comb begin
    kind_d = KIND_MISS;
    ppn_d  = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (hit2[w]) begin
        kind_d = spec2[w] ? KIND_SPEC : KIND_2M;
        ppn_d  = {ppn2[w][PPN_W-1:OFF_W], lkp_vpn_i[OFF_W-1:0]};
      end
    for (int w = WAYS-1; w >= 0; w--)
      if (hit4[w]) begin
        kind_d = KIND_4K;
        ppn_d  = ppn4[w];
      end
  end

  logic [PPN_W+1:0] res_o;
  l2tlb_pipe #(.W(PPN_W+2), .LAT(LAT)) u_pipe (
    .clk_i, .rst_ni, .valid_i(lkp_valid_i), .data_i({kind_d, ppn_d}),
    .valid_o(lkp_valid_o), .data_o(res_o)
  );
  assign lkp_kind_o = res_o[PPN_W+1:PPN_W];
  assign lkp_ppn_o  = res_o[PPN_W-1:0];

  AST_HIT4K_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |-> $onehot0(hit4)) // R8
    else $error("4KB translation held in two ways");

  AST_HIT2M_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |-> $onehot0(hit2)) // R8
    else $error("2MB frame held in two ways");
endmodule

// File: tb/l2tlb_skew_bench.sv
`timescale 1ns/1ps
module l2tlb_skew_bench;
  localparam int LAT = 7;
  localparam int WAYS = 4;
  localparam int SETS = 128;
  localparam int IW = 7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [35:0] lkp_vpn_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [35:0] fill_vpn_i = '0, fill_ppn_i = '0;
  logic        fill_big_i = 1'b0, fill_spec_i = 1'b0;
  logic        lkp_valid_o;
  logic [1:0]  lkp_kind_o;
  logic [35:0] lkp_ppn_o;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  l2tlb_skew u_l2tlb_skew (
    .clk_i(clk), .rst_ni, .lkp_valid_i, .lkp_vpn_i,
    .fill_valid_i, .fill_vpn_i, .fill_ppn_i, .fill_big_i, .fill_spec_i,
    .lkp_valid_o, .lkp_kind_o, .lkp_ppn_o
  );

  // reference model
  bit          mv [WAYS][SETS];
  bit          mb [WAYS][SETS];
  bit          ms [WAYS][SETS];
  logic [35:0] mt [WAYS][SETS];
  logic [35:0] mp [WAYS][SETS];
  int          rr = 0;

  function automatic int bidx(input logic [35:0] key, input int w);
    int r = 0;
    for (int i = 0; i < IW; i++) begin
      int src = (i - w + 2*IW) % IW;
      int b = key[i] ^ ((w == 0) ? 0 : key[IW + src]);
      r = r | (b << i);
    end
    return r;
  endfunction

  task automatic m_lookup(input logic [35:0] v, output logic [1:0] k, output logic [35:0] p);
    k = 2'd0; p = '0;
    for (int w = 0; w < WAYS; w++) begin
      int i = bidx(v, w);
      if (k == 0 && mv[w][i] && !mb[w][i] && mt[w][i] == v) begin k = 2'd1; p = mp[w][i]; end
    end
    if (k == 0)
      for (int w = 0; w < WAYS; w++) begin
        logic [35:0] key = v >> 9;
        int i = bidx(key, w);
        if (k == 0 && mv[w][i] && mb[w][i] && mt[w][i] == key) begin
          k = ms[w][i] ? 2'd3 : 2'd2;
          p = {mp[w][i][35:9], v[8:0]};
        end
      end
  endtask

  task automatic m_fill(input logic [35:0] v, input logic [35:0] p, input bit big, input bit spec);
    logic [35:0] key = big ? (v >> 9) : v;
    int way = -1;
    for (int w = 0; w < WAYS; w++) begin
      int i = bidx(key, w);
      if (way < 0 && mv[w][i] && mb[w][i] == big && mt[w][i] == key) way = w;
    end
    if (way < 0)
      for (int w = 0; w < WAYS; w++)
        if (way < 0 && !mv[w][bidx(key, w)]) way = w;
    if (way < 0) begin way = rr; rr = (rr + 1) % WAYS; end
    begin
      int i = bidx(key, way);
      mv[way][i] = 1; mb[way][i] = big; ms[way][i] = big && spec;
      mt[way][i] = key; mp[way][i] = p;
    end
  endtask

  task automatic check(input string req, input logic [1:0] k, input logic [35:0] p,
                       input logic [1:0] ek, input logic [35:0] ep);
    checks++;
    if (!lkp_valid_o || k !== ek || p !== ep) begin
      fails++;
      $display("FAIL %s: valid=%0b kind=%0d ppn=%h expected kind=%0d ppn=%h",
               req, lkp_valid_o, k, p, ek, ep);
    end
  endtask

  task automatic fill(input logic [35:0] v, input logic [35:0] p, input bit big, input bit spec);
    @(negedge clk);
    fill_valid_i = 1; fill_vpn_i = v; fill_ppn_i = p; fill_big_i = big; fill_spec_i = spec;
    m_fill(v, p, big, spec);
    @(negedge clk);
    fill_valid_i = 0;
  endtask

  // with_fill: a fill is sampled on the same edge as the lookup (R9)
  task automatic lookup(input string req, input logic [35:0] v,
                        input bit with_fill, input logic [35:0] fv, input logic [35:0] fp);
    logic [1:0] ek; logic [35:0] ep;
    m_lookup(v, ek, ep);
    @(negedge clk);
    lkp_valid_i = 1; lkp_vpn_i = v;
    if (with_fill) begin
      fill_valid_i = 1; fill_vpn_i = fv; fill_ppn_i = fp; fill_big_i = 0; fill_spec_i = 0;
      m_fill(fv, fp, 0, 0);
    end
    @(negedge clk);
    lkp_valid_i = 0; fill_valid_i = 0;
    repeat (LAT-2) @(negedge clk);
    checks++;
    if (lkp_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R2: valid=%0b one cycle early, expected 0", lkp_valid_o);
    end
    @(negedge clk);
    check(req, lkp_kind_o, lkp_ppn_o, ek, ep);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d expected under 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [35:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: empty after reset
    for (int n = 0; n < 8; n++) lookup("R1", {$urandom, 4'h0} ^ 36'(n * 513), 0, 0, 0);

    // R3: 4KB hit
    fill(36'h0_1234_5678, 36'h9_ABCD_EF01, 0, 1);   // spec ignored on 4KB (R5)
    lookup("R3", 36'h0_1234_5678, 0, 0, 0);
    lookup("R5", 36'h0_1234_5679, 0, 0, 0);

    // R4: true 2MB, low fill ppn bits discarded
    fill(36'h0_0AB0_0000, 36'h5_5555_51FF, 1, 0);
    for (int n = 0; n < 512; n += 97) lookup("R4", 36'h0_0AB0_0000 | 36'(n), 0, 0, 0);
    lookup("R4", 36'h0_0AB0_0200, 0, 0, 0);          // next frame: miss

    // R5: speculative 2MB
    fill(36'h3_0000_0E00, 36'h1_2345_6600, 1, 1);
    lookup("R5", 36'h3_0000_0E00, 0, 0, 0);
    lookup("R5", 36'h3_0000_0FFF, 0, 0, 0);

    // R6: 4KB inside the spec frame wins
    fill(36'h3_0000_0E42, 36'h7_7777_7777, 0, 0);
    lookup("R6", 36'h3_0000_0E42, 0, 0, 0);
    lookup("R6", 36'h3_0000_0E43, 0, 0, 0);

    // R8: in-place refill updates the page and kind
    fill(36'h3_0000_0E00, 36'h2_0000_0000, 1, 0);
    lookup("R8", 36'h3_0000_0E11, 0, 0, 0);

    // R7/R8: five keys with identical bits 13:0 share every way's slot
    for (int n = 1; n <= 5; n++) fill((36'(n) << 20) | 36'h1234, 36'(n * 1000), 0, 0);
    for (int n = 1; n <= 5; n++) lookup("R8", (36'(n) << 20) | 36'h1234, 0, 0, 0);
    fill(36'h0_0060_1234, 36'hA, 0, 0);
    for (int n = 1; n <= 6; n++) lookup("R8", (36'(n) << 20) | 36'h1234, 0, 0, 0);

    // R9: same-edge fill invisible, later visible
    lookup("R9", 36'h0_0F0F_0F0F, 1, 36'h0_0F0F_0F0F, 36'h0_0000_BEEF);
    lookup("R9", 36'h0_0F0F_0F0F, 0, 0, 0);

    // R7 sweep: clustered page numbers, mixed sizes
    for (int n = 0; n < 900; n++) begin
      v = '0;
      v[2:0] = 3'($urandom); v[9:8] = 2'($urandom); v[15:14] = 2'($urandom);
      v[24:22] = 3'($urandom); v[35:34] = 2'($urandom);
      if ($urandom_range(0, 2) == 0) fill(v, {$urandom, 4'($urandom)}, 1, 1'($urandom));
      else fill(v, {$urandom, 4'($urandom)}, 0, 0);
      v[2:0] = 3'($urandom); v[9:8] = 2'($urandom);
      lookup("R7", v, 0, 0, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule